// File: doc/BRIEF.md
# PWM Cycle Measurement with Timeout

The block watches one asynchronous digital input and reports, for each complete PWM cycle, how many clock ticks the signal spent at its active level and how many at its inactive level. A polarity input chooses which transition opens the active interval: with `start_on_rise` high a low-to-high transition begins it, with `start_on_rise` low a high-to-low transition begins it. A cycle spans one such opening transition to the next. When the closing transition is seen, both counts are published together and `result_valid` pulses for one clock.

A programmable tick limit bounds how long the block waits for a cycle to finish. If a cycle runs past the limit, both results are cleared to zero. They stay zero until a later cycle has been measured from start to end. The input passes through a synchronizer before edge detection, so it may come straight from a pin.

Top module: `pwm_meas_top`

## Requirements
- R1: The input passes through two synchronizing flops. `result_valid` and the results change at the second rising clock edge after the edge that first samples the closing transition.
- R2: With `start_on_rise` = 1 the active level is high, and a low-to-high transition opens the active interval and the cycle.
- R3: With `start_on_rise` = 0 the active level is low, and a high-to-low transition opens the active interval and the cycle.
- R4: `active_ticks` equals the number of clock samples at the active level in the cycle, counting the sample of the opening transition.
- R5: `inactive_ticks` equals the number of clock samples at the inactive level in the cycle.
- R6: Each complete cycle updates both results in the same clock, with a one-clock `result_valid` pulse. The first opening transition after reset or after a timeout only arms the measurement and produces no pulse.
- R7: A cycle whose length in ticks is less than or equal to `timeout_ticks` is reported normally.
- R8: When a cycle runs longer than `timeout_ticks` ticks, both results become zero and no `result_valid` pulse is issued for it.
- R9: After a timeout, the results remain zero across the next opening transition, until a full cycle has been measured.
- R10: After reset both results are zero and `result_valid` is low.
- R11: The tick counters saturate and never wrap. A cycle of 2^CNT_W-1 ticks with `timeout_ticks` at its maximum is reported exactly, and a longer cycle times out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock; the input is sampled on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous PWM input |
| start_on_rise | input | 1 | 1: rising transition starts the active interval; 0: falling transition does |
| timeout_ticks | input | CNT_W | Longest accepted cycle length in ticks |
| active_ticks | output | CNT_W | Ticks at the active level in the last measured cycle, or zero after a timeout |
| inactive_ticks | output | CNT_W | Ticks at the inactive level in the last measured cycle, or zero after a timeout |
| result_valid | output | 1 | One-clock pulse when a new cycle result is published |

## Verification
The bench builds the block with CNT_W = 8. This narrow width brings the counter ceiling of 255 ticks within a few hundred clocks, so a cycle of exactly the maximum length, and one tick beyond it, can both be driven directly. At that width every combination of 1 to 6 active and 1 to 6 inactive ticks is swept under both polarities, three periods each. The timeout is tested at a small limit with a period equal to the limit and one tick over it, followed by recovery through a fresh cycle while the pipeline latency is timed clock by clock.

// File: rtl/pwm_meas_pkg.sv
package pwm_meas_pkg;

    // Meaning of the polarity input
    typedef enum logic {
        POL_FALL_OPENS = 1'b0,
        POL_RISE_OPENS = 1'b1
    } open_pol_e;

    // Per-tick view of the synchronized input
    typedef struct packed {
        logic level_act;   // sampled level equals the active level
        logic open_edge;   // transition into the active level
    } tick_evt_t;

    localparam int unsigned MAX_CNT_W = 32;

    // Saturating increment on a value of up to MAX_CNT_W bits
    function automatic logic [MAX_CNT_W-1:0] sat_inc(
        input logic [MAX_CNT_W-1:0] val,
        input logic [MAX_CNT_W-1:0] ceiling
    );
        return (val >= ceiling) ? ceiling : val + 1'b1;
    endfunction

endpackage

// File: rtl/pwm_sync_edge.sv
module pwm_sync_edge
    import pwm_meas_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sig_in,
    input  logic      start_on_rise,
    output tick_evt_t evt
);
    localparam int unsigned CHAIN_LEN = SYNC_STAGES + 1;

    logic [CHAIN_LEN-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= sig_in;
    end

    for (genvar g = 1; g < CHAIN_LEN; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 1'b0;
            else     chain[g] <= chain[g-1];
        end
    end

    logic lvl_now, lvl_prev, act_now, act_prev;
    open_pol_e pol;

    always_comb begin
        pol      = open_pol_e'(start_on_rise);
        lvl_now  = chain[SYNC_STAGES-1];
        lvl_prev = chain[SYNC_STAGES];
        act_now  = (lvl_now  == pol);
        act_prev = (lvl_prev == pol);
        evt.level_act = act_now;
        evt.open_edge = act_now & ~act_prev;
    end

endmodule

// File: rtl/pwm_timeout_watch.sv
module pwm_timeout_watch
    import pwm_meas_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_edge,
    input  logic [CNT_W-1:0] timeout_ticks,
    output logic             armed,
    output logic             close_cycle,
    output logic             expire
);
    localparam logic [MAX_CNT_W-1:0] CEIL = MAX_CNT_W'({CNT_W{1'b1}});

    logic [CNT_W-1:0] elapsed;

    always_comb begin
        close_cycle = open_edge & armed;
        expire      = armed & ~open_edge & (elapsed >= timeout_ticks);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            elapsed <= '0;
        end else if (open_edge) begin
            armed   <= 1'b1;
            elapsed <= CNT_W'(1);
        end else if (expire) begin
            armed   <= 1'b0;
            elapsed <= '0;
        end else if (armed) begin
            elapsed <= CNT_W'(sat_inc(MAX_CNT_W'(elapsed), CEIL));
        end
    end

    // R6
    arm_after_open_chk: assert property (@(posedge clk) disable iff (rst)
        open_edge |=> armed);

endmodule

// File: rtl/pwm_span_count.sv
module pwm_span_count
    import pwm_meas_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  tick_evt_t        evt,
    input  logic             armed,
    output logic [CNT_W-1:0] act_cnt,
    output logic [CNT_W-1:0] ina_cnt
);
    localparam logic [MAX_CNT_W-1:0] CEIL = MAX_CNT_W'({CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cnt <= '0;
            ina_cnt <= '0;
        end else if (evt.open_edge) begin
            act_cnt <= CNT_W'(1);
            ina_cnt <= '0;
        end else if (armed) begin
            if (evt.level_act)
                act_cnt <= CNT_W'(sat_inc(MAX_CNT_W'(act_cnt), CEIL));
            else
                ina_cnt <= CNT_W'(sat_inc(MAX_CNT_W'(ina_cnt), CEIL));
        end
    end

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !evt.open_edge) |=>
            (act_cnt >= $past(act_cnt)) && (ina_cnt >= $past(ina_cnt)));

endmodule

// File: rtl/pwm_meas_top.sv
module pwm_meas_top
    import pwm_meas_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_in,
    input  logic             start_on_rise,
    input  logic [CNT_W-1:0] timeout_ticks,
    output logic [CNT_W-1:0] active_ticks,
    output logic [CNT_W-1:0] inactive_ticks,
    output logic             result_valid
);
    tick_evt_t        evt;
    logic             armed, close_cycle, expire;
    logic [CNT_W-1:0] act_cnt, ina_cnt;

    pwm_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk           (clk),
        .rst           (rst),
        .sig_in        (sig_in),
        .start_on_rise (start_on_rise),
        .evt           (evt)
    );

    pwm_timeout_watch #(.CNT_W(CNT_W)) u_tmo (
        .clk           (clk),
        .rst           (rst),
        .open_edge     (evt.open_edge),
        .timeout_ticks (timeout_ticks),
        .armed         (armed),
        .close_cycle   (close_cycle),
        .expire        (expire)
    );

    pwm_span_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .armed   (armed),
        .act_cnt (act_cnt),
        .ina_cnt (ina_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_ticks   <= '0;
            inactive_ticks <= '0;
            result_valid   <= 1'b0;
        end else if (close_cycle) begin
            active_ticks   <= act_cnt;
            inactive_ticks <= ina_cnt;
            result_valid   <= 1'b1;
        end else if (expire) begin
            active_ticks   <= '0;
            inactive_ticks <= '0;
            result_valid   <= 1'b0;
        end else begin
            result_valid   <= 1'b0;
        end
    end

    // R8
    zero_on_expire_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> (active_ticks == '0) && (inactive_ticks == '0) && !result_valid);

    // R4
    valid_has_active_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (active_ticks != '0));

    // R6
    valid_follows_close_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(close_cycle));

endmodule

// File: tb/test_pwm_meas_top.sv
module test_pwm_meas_top;
    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sig_in = 1'b0;
    logic         start_on_rise = 1'b1;
    logic [W-1:0] timeout_ticks = '1;
    logic [W-1:0] active_ticks, inactive_ticks;
    logic         result_valid;

    int total = 0;
    int bad   = 0;
    int pulses = 0;
    int exp_act = 0;
    int exp_ina = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_meas_top #(.CNT_W(W), .SYNC_STAGES(2)) i_pwm_meas_top (
        .clk            (clk),
        .rst            (rst),
        .sig_in         (sig_in),
        .start_on_rise  (start_on_rise),
        .timeout_ticks  (timeout_ticks),
        .active_ticks   (active_ticks),
        .inactive_ticks (inactive_ticks),
        .result_valid   (result_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R4 R5: every published result must match the expected counts
    always @(negedge clk) begin
        if (!rst && result_valid) begin
            pulses++;
            chk(active_ticks == W'(exp_act), "R4 active count", int'(active_ticks), exp_act);
            chk(inactive_ticks == W'(exp_ina), "R5 inactive count", int'(inactive_ticks), exp_ina);
        end
    end

    task automatic drive(input bit lvl, input int n);
        sig_in = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int p0;
        @(negedge clk);
        do_reset();
        // R10: reset state
        chk(active_ticks == 0, "R10 active after reset", int'(active_ticks), 0);
        chk(inactive_ticks == 0, "R10 inactive after reset", int'(inactive_ticks), 0);
        chk(result_valid == 0, "R10 valid after reset", int'(result_valid), 0);

        // R2 R3 R6: sweep of both polarities and small patterns
        for (int pol = 0; pol < 2; pol++) begin
            for (int a = 1; a <= 6; a++) begin
                for (int i = 1; i <= 6; i++) begin
                    start_on_rise = pol[0];
                    timeout_ticks = '1;
                    sig_in = ~pol[0];
                    do_reset();
                    exp_act = a;
                    exp_ina = i;
                    p0 = pulses;
                    drive(~pol[0], 4);
                    for (int k = 0; k < 3; k++) begin
                        drive(pol[0], a);
                        drive(~pol[0], i);
                    end
                    drive(pol[0], 4);
                    chk(pulses - p0 == 3, pol ? "R2 R6 pulse count" : "R3 R6 pulse count",
                        pulses - p0, 3);
                end
            end
        end

        // R8 R9 R1: timeout, recovery and latency
        start_on_rise = 1'b1;
        timeout_ticks = W'(20);
        sig_in = 1'b0;
        do_reset();
        exp_act = 4;
        exp_ina = 4;
        drive(0, 4);
        drive(1, 4); drive(0, 4);
        drive(1, 4); drive(0, 4);
        drive(1, 1);
        p0 = pulses;
        drive(1, 3);
        drive(0, 30);
        chk(pulses - p0 == 1, "R8 pulses before expiry", pulses - p0, 1);
        chk(active_ticks == 0, "R8 active zero", int'(active_ticks), 0);
        chk(inactive_ticks == 0, "R8 inactive zero", int'(inactive_ticks), 0);
        p0 = pulses;
        drive(1, 3);
        chk(active_ticks == 0, "R9 zero after re-arm", int'(active_ticks), 0);
        chk(pulses == p0, "R9 no pulse on re-arm", pulses - p0, 0);
        drive(0, 5);
        exp_act = 3;
        exp_ina = 5;
        sig_in = 1'b1;
        @(negedge clk);
        chk(result_valid == 0, "R1 valid after 1 edge", int'(result_valid), 0);
        @(negedge clk);
        chk(result_valid == 0, "R1 valid after 2 edges", int'(result_valid), 0);
        @(negedge clk);
        chk(result_valid == 1, "R1 valid after 3 edges", int'(result_valid), 1);
        drive(1, 3);

        // R7 R8: period equal to limit accepted, one over rejected
        start_on_rise = 1'b0;
        timeout_ticks = W'(10);
        sig_in = 1'b1;
        do_reset();
        exp_act = 3;
        exp_ina = 7;
        p0 = pulses;
        drive(1, 4);
        drive(0, 3); drive(1, 7);
        drive(0, 1);
        drive(0, 3);
        chk(pulses - p0 == 1, "R7 period at limit", pulses - p0, 1);
        chk(active_ticks == 3, "R7 active at limit", int'(active_ticks), 3);
        p0 = pulses;
        drive(1, 7);
        drive(0, 1);
        drive(0, 3);
        chk(pulses == p0, "R8 no pulse over limit", pulses - p0, 0);
        chk(inactive_ticks == 0, "R8 inactive over limit", int'(inactive_ticks), 0);

        // R11: full counter range and one beyond
        start_on_rise = 1'b1;
        timeout_ticks = '1;
        sig_in = 1'b0;
        do_reset();
        exp_act = 200;
        exp_ina = 55;
        p0 = pulses;
        drive(0, 3);
        drive(1, 200); drive(0, 55);
        drive(1, 1);
        drive(1, 3);
        chk(pulses - p0 == 1, "R11 full range pulse", pulses - p0, 1);
        chk(active_ticks == 200, "R11 full range active", int'(active_ticks), 200);
        p0 = pulses;
        drive(1, 196);
        drive(0, 56);
        drive(1, 4);
        chk(pulses == p0, "R11 over range no pulse", pulses - p0, 0);
        chk(active_ticks == 0, "R11 over range zero", int'(active_ticks), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule